// File: doc/BRIEF.md
# Two-Input Up/Down Step Decoder

This block turns two external signals, A and B, into single-cycle step pulses for a separate counter. One output pulse means "count up" and the other means "count down". A 2-bit mode input selects how direction is decided: a rising edge of A counted with B's level as direction (either polarity), separate rising edges on A and B for up and down, or full 4x quadrature decoding of both edges of both inputs. Both inputs cross into the clock domain through a flop synchronizer. Edges are found by comparing the two most recent synchronized samples.

The pulses are plain control outputs with no valid/ready handshake. They cannot be held back, and each event yields exactly one pulse one cycle wide. The block holds no counter and no compare or clear logic. In quadrature mode a change on both inputs at once is a lost step. It produces no pulse and sets a sticky error flag.

Top module: `updn_step_decoder`

## Requirements
- R1: A synchronous active-high reset clears all sample registers, both pulse outputs and the error flag. With both inputs low, no pulse appears after reset is released.
- R2: With two synchronizer stages, a qualifying input change made between clock edges gives a pulse that is high for exactly one cycle, after the third rising edge that follows the change.
- R3: With mode = 2'b00, a rising edge of A produces an up pulse if B is low and a down pulse if B is high.
- R4: With mode = 2'b01, a rising edge of A produces an up pulse and a rising edge of B produces a down pulse.
- R5: With mode = 2'b01, if A and B rise in the same cycle, the two events cancel and no pulse is produced.
- R6: With mode = 2'b10, a rising edge of A produces an up pulse if B is high and a down pulse if B is low.
- R7: With mode = 2'b11, each step of {A,B} along 00→01→11→10→00 produces one up pulse, and each step along the reverse order produces one down pulse.
- R8: With mode = 2'b11, a change of both A and B in one cycle produces no pulse and sets seq_error. The flag stays set until reset.
- R9: up_pulse and down_pulse are never high in the same cycle.
- R10: In modes 2'b00, 2'b01 and 2'b10, falling edges produce no pulse. In modes 2'b00 and 2'b10, edges on B produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | External input A (asynchronous) |
| in_b | input | 1 | External input B (asynchronous) |
| mode | input | 2 | Direction mode: 00 level-gated, 01 split, 10 A-edge gated, 11 quadrature |
| up_pulse | output | 1 | One-cycle count-up pulse |
| down_pulse | output | 1 | One-cycle count-down pulse |
| seq_error | output | 1 | Sticky flag: illegal two-input jump seen in quadrature mode |

## Verification
The bench walks each mode through edges of both polarities. Where a decoder swaps the B-level polarity between the two gated modes, the bench sees pulses in the wrong direction. Where a decoder counts falling edges or B edges, it sees extra pulses. It makes A and B rise together in split mode; a decoder without cancellation would emit an up or a down pulse there. It runs full forward and reverse quadrature cycles and then an illegal diagonal jump. A decoder that treated the jump as a double step would emit a pulse, and one with a non-sticky flag would lose the error on the next legal step. It also times one pulse to the exact cycle, to catch an extra or missing pipeline stage.

// File: rtl/udd_pkg.sv
package udd_pkg;
  typedef enum logic [1:0] {
    DIR_LEVEL = 2'b00,
    DIR_SPLIT = 2'b01,
    DIR_GATED = 2'b10,
    DIR_QUAD  = 2'b11
  } dir_mode_e;

  localparam int unsigned MIN_SYNC_DEPTH = 2;

  // Position of a two-bit {A,B} state along the forward cycle 00,01,11,10.
  function automatic logic [1:0] quad_pos(input logic [1:0] ab);
    quad_pos = {ab[1], ab[1] ^ ab[0]};
  endfunction
endpackage

// File: rtl/udd_sync.sv
module udd_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);
  localparam int unsigned TAPS = DEPTH + 1;

  logic [WIDTH-1:0] pipe [TAPS];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= din;
  end

  for (genvar s = 1; s < TAPS; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '0;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign cur  = pipe[DEPTH-1];
  assign prev = pipe[DEPTH];
endmodule

// File: rtl/udd_quad.sv
module udd_quad
  import udd_pkg::*;
(
  input  logic [1:0] ab_cur,
  input  logic [1:0] ab_prev,
  output logic       q_up,
  output logic       q_dn,
  output logic       q_bad
);
  logic [1:0] delta;

  always_comb begin
    delta = quad_pos(ab_cur) - quad_pos(ab_prev);
    q_up  = (delta == 2'd1);
    q_dn  = (delta == 2'd3);
    q_bad = (delta == 2'd2);
  end
endmodule

// File: rtl/udd_step.sv
module udd_step
  import udd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  dir_mode_e mode,
  input  logic      a_cur,
  input  logic      a_prev,
  input  logic      b_cur,
  input  logic      b_prev,
  input  logic      q_up,
  input  logic      q_dn,
  input  logic      q_bad,
  output logic      up_q,
  output logic      dn_q,
  output logic      err_q
);
  logic a_rise, b_rise, any_chg;
  logic up_n, dn_n, bad_n;

  assign a_rise  = a_cur & ~a_prev;
  assign b_rise  = b_cur & ~b_prev;
  assign any_chg = (a_cur ^ a_prev) | (b_cur ^ b_prev);

  always_comb begin
    up_n  = 1'b0;
    dn_n  = 1'b0;
    bad_n = 1'b0;
    unique case (mode)
      DIR_LEVEL: begin
        up_n = a_rise & ~b_cur;
        dn_n = a_rise &  b_cur;
      end
      DIR_SPLIT: begin
        up_n = a_rise & ~b_rise;
        dn_n = b_rise & ~a_rise;
      end
      DIR_GATED: begin
        up_n = a_rise &  b_cur;
        dn_n = a_rise & ~b_cur;
      end
      DIR_QUAD: begin
        up_n  = q_up;
        dn_n  = q_dn;
        bad_n = q_bad;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      up_q  <= up_n;
      dn_q  <= dn_n;
      err_q <= err_q | bad_n;
    end
  end

  // R9
  excl_pulse_chk: assert property (@(posedge clk) disable iff (rst) !(up_q && dn_q));

  // R2
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    any_chg or !(up_n || dn_n));

  // R5
  split_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == DIR_SPLIT && a_rise && b_rise) |=> !(up_q || dn_q));

  // R8
  quad_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == DIR_QUAD && (a_cur ^ a_prev) && (b_cur ^ b_prev)) |=> (!up_q && !dn_q && err_q));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err_q |=> err_q);
endmodule

// File: rtl/updn_step_decoder.sv
module updn_step_decoder
  import udd_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_a,
  input  logic       in_b,
  input  logic [1:0] mode,
  output logic       up_pulse,
  output logic       down_pulse,
  output logic       seq_error
);
  localparam int unsigned DEPTH = (SYNC_DEPTH < MIN_SYNC_DEPTH) ? MIN_SYNC_DEPTH : SYNC_DEPTH;

  logic [1:0] ab_cur, ab_prev;
  logic       q_up, q_dn, q_bad;

  udd_sync #(.WIDTH(2), .DEPTH(DEPTH)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({in_a, in_b}),
    .cur  (ab_cur),
    .prev (ab_prev)
  );

  udd_quad u_quad (
    .ab_cur  (ab_cur),
    .ab_prev (ab_prev),
    .q_up    (q_up),
    .q_dn    (q_dn),
    .q_bad   (q_bad)
  );

  udd_step u_step (
    .clk    (clk),
    .rst    (rst),
    .mode   (dir_mode_e'(mode)),
    .a_cur  (ab_cur[1]),
    .a_prev (ab_prev[1]),
    .b_cur  (ab_cur[0]),
    .b_prev (ab_prev[0]),
    .q_up   (q_up),
    .q_dn   (q_dn),
    .q_bad  (q_bad),
    .up_q   (up_pulse),
    .dn_q   (down_pulse),
    .err_q  (seq_error)
  );
endmodule

// File: tb/test_updn_step_decoder.sv
`timescale 1ns/1ps
module test_updn_step_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_a = 1'b0;
  logic       in_b = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       up_pulse, down_pulse, seq_error;

  int    n_cmp  = 0;
  int    n_bad  = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";
  int    exp_q[$];

  localparam int NONE = 0, UP = 1, DN = 2;

  always #2.5 clk = ~clk;

  updn_step_decoder i_updn_step_decoder (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .mode(mode),
    .up_pulse(up_pulse), .down_pulse(down_pulse), .seq_error(seq_error)
  );

  // Monitor: pops expected pulses and compares them with what appears.
  always @(negedge clk) begin
    if (!rst) begin
      if (up_pulse && down_pulse) begin
        n_cmp++; n_bad++;
        $display("FAIL R9: up=%0b down=%0b expected not both", up_pulse, down_pulse);
      end else if (up_pulse || down_pulse) begin
        int got;
        got = up_pulse ? UP : DN;
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL %s: pulse code %0d expected none", cur_req, got);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != got) begin
            n_bad++;
            $display("FAIL %s: pulse code %0d expected %0d", cur_req, got, e);
          end
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_a = 1'b0; in_b = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input logic na, input logic nb, input int e, input string req);
    cur_req = req;
    if (e != NONE) exp_q.push_back(e);
    in_a = na; in_b = nb;
    repeat (6) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: %0d pulse(s) missing, expected code %0d", req, exp_q.size(), e);
      exp_q.delete();
    end
  endtask

  task automatic chk_err(input logic e, input string req);
    n_cmp++;
    if (seq_error !== e) begin
      n_bad++;
      $display("FAIL %s: seq_error=%0b expected %0b", req, seq_error, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    n_cmp++;
    if (up_pulse !== 1'b0 || down_pulse !== 1'b0 || seq_error !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: up=%0b down=%0b err=%0b expected 0 0 0", up_pulse, down_pulse, seq_error);
    end
    step(1'b0, 1'b0, NONE, "R1");

    // R2: exact latency, split mode, A rises
    mode = 2'b01;
    @(negedge clk);
    cur_req = "R2";
    exp_q.push_back(UP);
    in_a = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      n_cmp++;
      if (up_pulse !== (k == 3)) begin
        n_bad++;
        $display("FAIL R2: cycle %0d up=%0b expected %0b", k, up_pulse, (k == 3));
      end
    end
    step(1'b1, 1'b0, NONE, "R2");
    step(1'b0, 1'b0, NONE, "R10");

    // Mode 00: level-gated, B high = down
    mode = 2'b00;
    step(1'b1, 1'b0, UP,   "R3");
    step(1'b0, 1'b0, NONE, "R10");
    step(1'b0, 1'b1, NONE, "R10");
    step(1'b1, 1'b1, DN,   "R3");
    step(1'b0, 1'b1, NONE, "R10");
    step(1'b0, 1'b0, NONE, "R10");

    // Mode 01: split inputs
    mode = 2'b01;
    step(1'b1, 1'b0, UP,   "R4");
    step(1'b0, 1'b0, NONE, "R10");
    step(1'b0, 1'b1, DN,   "R4");
    step(1'b0, 1'b0, NONE, "R10");
    step(1'b1, 1'b1, NONE, "R5");
    step(1'b0, 1'b0, NONE, "R10");

    // Mode 10: A edge, B high = up
    mode = 2'b10;
    step(1'b0, 1'b1, NONE, "R10");
    step(1'b1, 1'b1, UP,   "R6");
    step(1'b0, 1'b1, NONE, "R10");
    step(1'b0, 1'b0, NONE, "R10");
    step(1'b1, 1'b0, DN,   "R6");
    step(1'b0, 1'b0, NONE, "R10");

    // Mode 11: quadrature, {A,B}
    mode = 2'b11;
    step(1'b0, 1'b1, UP, "R7");
    step(1'b1, 1'b1, UP, "R7");
    step(1'b1, 1'b0, UP, "R7");
    step(1'b0, 1'b0, UP, "R7");
    step(1'b1, 1'b0, DN, "R7");
    step(1'b1, 1'b1, DN, "R7");
    step(1'b0, 1'b1, DN, "R7");
    step(1'b0, 1'b0, DN, "R7");
    chk_err(1'b0, "R8");
    step(1'b1, 1'b1, NONE, "R8");
    chk_err(1'b1, "R8");
    step(1'b1, 1'b0, UP, "R7");
    chk_err(1'b1, "R8");
    step(1'b0, 1'b0, UP, "R7");

    do_reset();
    chk_err(1'b0, "R1");
    step(1'b0, 1'b0, NONE, "R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule